// File: doc/BRIEF.md
# Hsync-Referenced Clamp Pulse Generator

This block times a black-level clamp pulse from the trailing (falling) edge of an active-high horizontal sync. It runs on the pixel clock. The sync input first passes through a two-flop synchronizer, and a third register then detects the falling edge. At that edge the block captures two settings: the placement (the delay in pixel periods) and the duration (the pulse width in pixel periods). It then runs a three-state machine: `ST_IDLE`, `ST_DELAY` and `ST_CLAMP`.

The state machine has these transitions:

- `TR_START`: a trailing edge with a non-zero duration moves any state to `ST_DELAY`.
- `TR_SKIP`: a trailing edge with a zero duration moves any state to `ST_IDLE`.
- `TR_FIRE`: `ST_DELAY` moves to `ST_CLAMP` when the delay count is used up.
- `TR_DONE`: `ST_CLAMP` moves to `ST_IDLE` when the width count is used up.

A trailing edge overrides every other transition, which restarts any sequence in flight.

Some placement values cannot be used. When one of them is captured, the block substitutes the next usable value and raises a sticky error flag. A source-select input hands the output to an external clamp signal, and the placement setting then has no effect.

Top module: `clamp_gen`

## Requirements
- R1: Let edge 0 be the first rising clock edge that samples `hsync_in` low after it was high for at least 3 cycles. With a usable placement P and a duration D > 0, `clamp_out` is low after edges 0 through P+1 and rises after edge P+2.
- R2: Once risen, `clamp_out` stays high for exactly D clock cycles and falls after edge P+2+D.
- R3: A duration of 0 produces no clamp pulse for that line.
- R4: A placement value with fewer than two bits set is unusable. Values 0, 1 and 2 are treated as 3. A power of two from 4 to 128 is treated as that value plus 1.
- R5: `place_err` goes high when an unusable placement is captured at a trailing edge in internal mode. It stays high until reset, and it is never set in external mode.
- R6: A new trailing edge during a delay or a pulse restarts the timing of R1 and R2 from the new edge. No pulse from the earlier edge appears.
- R7: `place_cfg` and `dur_cfg` are sampled only at the trailing edge. Changing them mid-line does not alter the pulse already scheduled.
- R8: When `ext_sel` is 1, `clamp_out` equals `ext_clamp` in the same cycle, and the internal timing has no effect on it.
- R9: After reset, `clamp_out` is low (in internal mode), `place_err` is low, and the machine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Asynchronous active-high horizontal sync |
| place_cfg | input | 8 | Delay from the trailing edge, in pixel periods |
| dur_cfg | input | 8 | Clamp width in pixel periods (0 = no pulse) |
| ext_sel | input | 1 | 1 selects the external clamp source |
| ext_clamp | input | 1 | External clamp input |
| clamp_out | output | 1 | Clamp pulse |
| place_err | output | 1 | Sticky flag for an unusable placement |

## Verification
The sync path has three registers and the capture adds one more. As a result, the pulse rises P+3 clock cycles after the cycle in which the bench drives `hsync_in` low, and it falls D cycles later. The external path is combinational and is due in the same cycle. The driver task pushes one expected value per cycle, starting at the cycle of the falling sync. The monitor pops one value per cycle, 1 ns after each falling clock edge, so every comparison lands on the exact cycle in which the result is due. The error flag is checked directly after each line has finished.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_CLAMP = 2'd2
    } clamp_st_e;

endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic trail_out
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], async_in};
    end

    // falling edge seen between the last synchronizer stage and the edge register
    assign trail_out = chain[LAST] & ~chain[LAST-1];

endmodule

// File: rtl/clamp_place_fix.sv
module clamp_place_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] place_raw,
    output logic [W-1:0] place_eff,
    output logic         place_bad
);
    localparam logic [W-1:0] MIN_OK = W'(3);

    always_comb begin
        place_bad = ($countones(place_raw) < 2);
        if (place_raw < MIN_OK)  place_eff = MIN_OK;
        else if (place_bad)      place_eff = place_raw + 1'b1;
        else                     place_eff = place_raw;
    end

endmodule

// File: rtl/clamp_fsm.sv
module clamp_fsm
    import clamp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trail,
    input  logic [W-1:0] place_eff,
    input  logic         place_bad,
    input  logic [W-1:0] dur_cfg,
    input  logic         ext_sel,
    output logic         clamp_int,
    output logic         err_flag
);
    localparam logic [W-1:0] ZERO = '0;

    clamp_st_e st, st_nxt;
    logic [W-1:0] cnt;
    logic [W-1:0] dur_q;

    // next state
    always_comb begin
        st_nxt = st;
        if (trail) begin
            st_nxt = (dur_cfg != ZERO) ? ST_DELAY : ST_IDLE;     // TR_START / TR_SKIP
        end else begin
            unique case (st)
                ST_IDLE:  st_nxt = ST_IDLE;
                ST_DELAY: if (cnt == ZERO) st_nxt = ST_CLAMP;    // TR_FIRE
                ST_CLAMP: if (cnt == ZERO) st_nxt = ST_IDLE;     // TR_DONE
                default:  st_nxt = ST_IDLE;
            endcase
        end
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            dur_q    <= '0;
            err_flag <= 1'b0;
        end else begin
            st <= st_nxt;
            if (trail) begin
                cnt   <= place_eff - 1'b1;
                dur_q <= dur_cfg;
                if (place_bad && !ext_sel) err_flag <= 1'b1;
            end else begin
                unique case (st)
                    ST_IDLE:  cnt <= cnt;
                    ST_DELAY: cnt <= (cnt == ZERO) ? dur_q - 1'b1 : cnt - 1'b1;
                    ST_CLAMP: if (cnt != ZERO) cnt <= cnt - 1'b1;
                    default:  cnt <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        clamp_int = (st == ST_CLAMP);
    end

endmodule

// File: rtl/clamp_gen.sv
module clamp_gen #(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hsync_in,
    input  logic [W-1:0] place_cfg,
    input  logic [W-1:0] dur_cfg,
    input  logic         ext_sel,
    input  logic         ext_clamp,
    output logic         clamp_out,
    output logic         place_err
);
    logic         trail;
    logic [W-1:0] place_eff;
    logic         place_bad;
    logic         clamp_int;

    clamp_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (hsync_in),
        .trail_out (trail)
    );

    clamp_place_fix #(.W(W)) u_fix (
        .place_raw (place_cfg),
        .place_eff (place_eff),
        .place_bad (place_bad)
    );

    clamp_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trail     (trail),
        .place_eff (place_eff),
        .place_bad (place_bad),
        .dur_cfg   (dur_cfg),
        .ext_sel   (ext_sel),
        .clamp_int (clamp_int),
        .err_flag  (place_err)
    );

    assign clamp_out = ext_sel ? ext_clamp : clamp_int;

endmodule

// File: rtl/clamp_gen_chk.sv
module clamp_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         trail,
    input logic [W-1:0] dur_cfg,
    input logic         clamp_int,
    input logic         place_err
);
    localparam logic [W:0] MAX_RUN = (W+1)'((1 << W) - 1);

    logic [W:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)         run <= '0;
        else if (clamp_int) run <= run + 1'b1;
        else                run <= '0;
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n) run <= MAX_RUN); // R2
    AST_ZERO_DUR: assert property (@(posedge clk) disable iff (!rst_n) (trail && dur_cfg == '0) |=> !clamp_int); // R3
    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n) trail |=> !clamp_int); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) place_err |=> place_err); // R5
    AST_ERR_AT_TRAIL: assert property (@(posedge clk) disable iff (!rst_n) $rose(place_err) |-> $past(trail)); // R5

endmodule

bind clamp_gen clamp_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trail     (trail),
    .dur_cfg   (dur_cfg),
    .clamp_int (clamp_int),
    .place_err (place_err)
);

// File: tb/clamp_gen_bench.sv
`timescale 1ns/1ps
module clamp_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic [7:0] place_cfg = 8'd5;
    logic [7:0] dur_cfg = 8'd4;
    logic       ext_sel = 1'b0;
    logic       ext_clamp = 1'b0;
    logic       clamp_out;
    logic       place_err;

    int checks = 0;
    int errors = 0;

    typedef struct { bit v; string tag; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    clamp_gen u_clamp_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_in  (hsync_in),
        .place_cfg (place_cfg),
        .dur_cfg   (dur_cfg),
        .ext_sel   (ext_sel),
        .ext_clamp (ext_clamp),
        .clamp_out (clamp_out),
        .place_err (place_err)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: one expected item per cycle, sampled 1 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(clamp_out, e.v, e.tag);
            end
        end
    end

    // driver: one line, with an optional restart and an optional mid-line setting change
    task automatic run_line(input int p_cfg, input int d_cfg, input int p_exp,
                            input int rst_at, input int mid_at, input bit ext,
                            input string tag);
        int off;
        int len;
        off = (rst_at > 0) ? rst_at : 0;
        len = off + p_exp + d_cfg + 8;
        @(negedge clk);
        place_cfg = 8'(p_cfg);
        dur_cfg   = 8'(d_cfg);
        hsync_in  = 1'b1;
        repeat (3) @(negedge clk);
        hsync_in = 1'b0;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            e.v   = !ext && (k >= off + p_exp + 3) && (k < off + p_exp + d_cfg + 3);
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            if (rst_at > 0 && k == rst_at - 2) hsync_in = 1'b1;
            if (rst_at > 0 && k == rst_at)     hsync_in = 1'b0;
            if (k == mid_at) begin
                place_cfg = 8'd3;
                dur_cfg   = 8'd1;
            end
        end
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(clamp_out, 1'b0, "R9 clamp low after reset");
        check(place_err, 1'b0, "R9 err low after reset");

        run_line(5, 4, 5, 0, -1, 1'b0, "R1 R2 place5 dur4");
        run_line(3, 1, 3, 0, -1, 1'b0, "R1 R2 place3 dur1");
        run_line(200, 255, 200, 0, -1, 1'b0, "R2 place200 dur255");
        run_line(6, 0, 6, 0, -1, 1'b0, "R3 zero duration");
        run_line(10, 4, 10, 7, -1, 1'b0, "R6 restart");
        run_line(12, 6, 12, 0, 17, 1'b0, "R7 mid-line change");
        #1;
        check(place_err, 1'b0, "R5 no err for usable placement");

        // external mode
        @(negedge clk);
        ext_sel = 1'b1; ext_clamp = 1'b1;
        #1 check(clamp_out, 1'b1, "R8 ext pass high");
        ext_clamp = 1'b0;
        #1 check(clamp_out, 1'b0, "R8 ext pass low");
        run_line(16, 5, 17, 0, -1, 1'b1, "R8 internal timing ignored");
        #1 check(place_err, 1'b0, "R5 R8 no err in external mode");
        ext_sel = 1'b0;

        run_line(8, 3, 9, 0, -1, 1'b0, "R4 place8 as 9");
        #1 check(place_err, 1'b1, "R5 err set on unusable placement");
        run_line(0, 2, 3, 0, -1, 1'b0, "R4 place0 as 3");
        run_line(1, 2, 3, 0, -1, 1'b0, "R4 place1 as 3");
        run_line(128, 2, 129, 0, -1, 1'b0, "R4 place128 as 129");
        run_line(7, 2, 7, 0, -1, 1'b0, "R1 place7 after errors");
        #1 check(place_err, 1'b1, "R5 err sticky");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule